// File: doc/BRIEF.md
# Fast Ethernet 5B/4B receive decoder

This block sits behind the code-group aligner of a 100 Mb/s receive path. Every clock in which `cg_valid` is high, it takes one aligned 5-bit code group. It stays silent until it sees the two-symbol start-of-stream delimiter. It then drives a nibble stream with data-valid and error flags towards a media-independent-interface style receiver.

The delimiter symbols are not dropped. Each one is replaced by a preamble nibble, so the MAC sees a normal preamble. Every later code group is translated through the 4B/5B data table. The end-of-stream pair is consumed without producing any nibble.

A broken delimiter is reported as a false carrier. Symbols that are not data inside a frame are flagged as errors. Two IDLE symbols in a row inside a frame are treated as a premature end.

All results are registered. The outputs for a code group appear one clock after the edge that accepts it. In code values below, the value is written as `cg_data[4:0]`, most significant bit first.

Top module: `rx5b_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, `rx_dv`, `rx_er` and `rxd` become 0 and the decoder returns to the search for a delimiter, so a later K symbol alone produces no output activity.
- R2: While searching, any accepted code group other than J (11000) gives `rx_dv`=0, `rx_er`=0, `rxd`=0000, including K, IDLE, T and data symbols.
- R3: An accepted J while searching gives `rx_dv`=1, `rx_er`=0, `rxd`=0101; `rx_dv` never rises without `rxd`=0101.
- R4: A K (10001) accepted directly after that J gives `rx_dv`=1, `rx_er`=0, `rxd`=0101 and starts frame decoding.
- R5: Any code group other than K accepted directly after that J gives `rx_dv`=0, `rx_er`=1, `rxd`=1110 (false carrier), and the search restarts.
- R6: During a frame, each data symbol gives `rx_dv`=1, `rx_er`=0 and its nibble: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R7: During a frame, T (01101) gives `rx_dv`=0, `rx_er`=0, `rxd`=0000; an R (00111) accepted next also gives all zeros, and the search restarts.
- R8: If the code group accepted after that T is not R, the outputs are `rx_dv`=0, `rx_er`=1, `rxd`=0000 for that group, and the search restarts.
- R9: During a frame, a first IDLE (11111) gives `rx_dv`=1, `rx_er`=1, `rxd`=0000. A second IDLE directly after it gives all zeros and restarts the search. Any other symbol after a single IDLE is decoded as a normal frame symbol.
- R10: During a frame, any code group that is not data, T or IDLE gives `rx_dv`=1, `rx_er`=1, `rxd`=0000, and decoding continues.
- R11: In a cycle with `cg_valid` low, `cg_data` is ignored. Outputs and decoder state keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cg_valid | input | 1 | Qualifies `cg_data` in this cycle |
| cg_data | input | 5 | Aligned code group |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rxd | output | 4 | Receive nibble |

## Verification
Every result belongs to exactly one accepted code group. It is due on the outputs after the single rising edge that accepts that group, and it then stays in place through any stalled cycles. The bench changes `cg_valid` and `cg_data` only on falling edges. It compares outputs on the next falling edge, so exactly one accepting edge lies between a stimulus and its check. Stall and reset checks use the same timing: the outputs are held, or cleared, one edge later.

// File: rtl/rx5b_pkg.sv
package rx5b_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    typedef logic [CG_W-1:0]  cg_t;
    typedef logic [NIB_W-1:0] nib_t;

    // control symbols
    localparam cg_t SYM_IDLE = 5'b11111;
    localparam cg_t SYM_J    = 5'b11000;
    localparam cg_t SYM_K    = 5'b10001;
    localparam cg_t SYM_T    = 5'b01101;
    localparam cg_t SYM_R    = 5'b00111;

    localparam nib_t NIB_PREAMBLE = 4'b0101;
    localparam nib_t NIB_FALSECAR = 4'b1110;
    localparam nib_t NIB_ZERO     = '0;

    typedef enum logic [2:0] {
        CLS_DATA,
        CLS_IDLE,
        CLS_J,
        CLS_K,
        CLS_T,
        CLS_R,
        CLS_BAD
    } cg_class_e;

    typedef struct packed {
        cg_class_e cls;
        nib_t      nib;
    } cg_info_t;

    typedef enum logic [2:0] {
        ST_SEEK_J,
        ST_SEEK_K,
        ST_DECODE,
        ST_IDLE1,
        ST_SEEK_R
    } rx_state_e;

    typedef struct packed {
        logic dv;
        logic er;
        nib_t nib;
    } mii_out_t;

    typedef struct packed {
        rx_state_e nxt;
        mii_out_t  out;
    } step_t;

    localparam mii_out_t MII_QUIET = '{dv: 1'b0, er: 1'b0, nib: NIB_ZERO};

    function automatic cg_info_t classify_cg(input cg_t c);
        cg_info_t r;
        r.cls = CLS_DATA;
        r.nib = NIB_ZERO;
        case (c)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            SYM_IDLE: r.cls = CLS_IDLE;
            SYM_J:    r.cls = CLS_J;
            SYM_K:    r.cls = CLS_K;
            SYM_T:    r.cls = CLS_T;
            SYM_R:    r.cls = CLS_R;
            default:  r.cls = CLS_BAD;
        endcase
        return r;
    endfunction

    // one symbol inside a frame (no pending IDLE)
    function automatic step_t frame_step(input cg_info_t i);
        step_t s;
        case (i.cls)
            CLS_DATA: s = '{nxt: ST_DECODE, out: '{dv: 1'b1, er: 1'b0, nib: i.nib}};
            CLS_IDLE: s = '{nxt: ST_IDLE1,  out: '{dv: 1'b1, er: 1'b1, nib: NIB_ZERO}};
            CLS_T:    s = '{nxt: ST_SEEK_R, out: MII_QUIET};
            default:  s = '{nxt: ST_DECODE, out: '{dv: 1'b1, er: 1'b1, nib: NIB_ZERO}};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rx5b_classify.sv
module rx5b_classify
    import rx5b_pkg::*;
(
    input  cg_t      cg,
    output cg_info_t info
);
    always_comb begin
        info = classify_cg(cg);
    end
endmodule

// File: rtl/rx5b_ctrl.sv
module rx5b_ctrl
    import rx5b_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  cg_info_t info,
    output mii_out_t out_nxt
);
    rx_state_e state_q;
    step_t     res;

    always_comb begin
        res = '{nxt: state_q, out: MII_QUIET};
        case (state_q)
            ST_SEEK_J: begin
                if (info.cls == CLS_J)
                    res = '{nxt: ST_SEEK_K, out: '{dv: 1'b1, er: 1'b0, nib: NIB_PREAMBLE}};
                else
                    res = '{nxt: ST_SEEK_J, out: MII_QUIET};
            end
            ST_SEEK_K: begin
                if (info.cls == CLS_K)
                    res = '{nxt: ST_DECODE, out: '{dv: 1'b1, er: 1'b0, nib: NIB_PREAMBLE}};
                else
                    res = '{nxt: ST_SEEK_J, out: '{dv: 1'b0, er: 1'b1, nib: NIB_FALSECAR}};
            end
            ST_DECODE: begin
                res = frame_step(info);
            end
            ST_IDLE1: begin
                if (info.cls == CLS_IDLE)
                    res = '{nxt: ST_SEEK_J, out: MII_QUIET};
                else
                    res = frame_step(info);
            end
            ST_SEEK_R: begin
                if (info.cls == CLS_R)
                    res = '{nxt: ST_SEEK_J, out: MII_QUIET};
                else
                    res = '{nxt: ST_SEEK_J, out: '{dv: 1'b0, er: 1'b1, nib: NIB_ZERO}};
            end
            default: res = '{nxt: ST_SEEK_J, out: MII_QUIET};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_SEEK_J;
        else if (adv)
            state_q <= res.nxt;
    end

    assign out_nxt = res.out;
endmodule

// File: rtl/rx5b_outreg.sv
module rx5b_outreg
    import rx5b_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  mii_out_t d,
    output mii_out_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= MII_QUIET;
        else if (adv)
            q <= d;
    end
endmodule

// File: rtl/rx5b_decoder.sv
module rx5b_decoder
    import rx5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cg_valid,
    input  logic [CG_W-1:0]  cg_data,
    output logic             rx_dv,
    output logic             rx_er,
    output logic [NIB_W-1:0] rxd
);
    cg_info_t info;
    mii_out_t out_nxt;
    mii_out_t out_q;

    rx5b_classify u_classify (
        .cg   (cg_data),
        .info (info)
    );

    rx5b_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .adv     (cg_valid),
        .info    (info),
        .out_nxt (out_nxt)
    );

    rx5b_outreg u_outreg (
        .clk (clk),
        .rst (rst),
        .adv (cg_valid),
        .d   (out_nxt),
        .q   (out_q)
    );

    assign rx_dv = out_q.dv;
    assign rx_er = out_q.er;
    assign rxd   = out_q.nib;
endmodule

// File: rtl/rx5b_decoder_chk.sv
module rx5b_decoder_chk
    import rx5b_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cg_valid,
    input logic [CG_W-1:0]  cg_data,
    input logic             rx_dv,
    input logic             rx_er,
    input logic [NIB_W-1:0] rxd
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cg_valid |=> ($stable(rx_dv) && $stable(rx_er) && $stable(rxd))); // R11

    AST_DV_RISE_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_dv) |-> (rxd == NIB_PREAMBLE && !rx_er)); // R3

    AST_DV_FALL_FORM: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_dv) |-> (rx_er ? (rxd == NIB_FALSECAR) : (rxd == NIB_ZERO))); // R5 R7

    AST_ER_IN_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rx_dv && rx_er) |-> (rxd == NIB_ZERO)); // R10

    AST_ERR_NO_DV_SHORT: assert property (@(posedge clk) disable iff (rst)
        (rx_er && !rx_dv && cg_valid) |=> !rx_er); // R8
endmodule

bind rx5b_decoder rx5b_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cg_valid (cg_valid),
    .cg_data  (cg_data),
    .rx_dv    (rx_dv),
    .rx_er    (rx_er),
    .rxd      (rxd)
);

// File: tb/rx5b_decoder_test.sv
module rx5b_decoder_test;

    localparam logic [4:0] C_I = 5'b11111;
    localparam logic [4:0] C_J = 5'b11000;
    localparam logic [4:0] C_K = 5'b10001;
    localparam logic [4:0] C_T = 5'b01101;
    localparam logic [4:0] C_R = 5'b00111;
    localparam logic [4:0] C_H = 5'b00100;

    // entry: {code, dv, er, nibble}
    localparam int NV = 28;
    localparam logic [10:0] VEC [0:NV-1] = '{
        {C_I,      2'b00, 4'h0},
        {C_H,      2'b00, 4'h0},
        {C_K,      2'b00, 4'h0},
        {C_J,      2'b10, 4'h5},
        {C_K,      2'b10, 4'h5},
        {5'b11110, 2'b10, 4'h0},
        {5'b01001, 2'b10, 4'h1},
        {5'b10100, 2'b10, 4'h2},
        {5'b10101, 2'b10, 4'h3},
        {5'b01010, 2'b10, 4'h4},
        {5'b01011, 2'b10, 4'h5},
        {5'b01110, 2'b10, 4'h6},
        {5'b01111, 2'b10, 4'h7},
        {5'b10010, 2'b10, 4'h8},
        {5'b10011, 2'b10, 4'h9},
        {5'b10110, 2'b10, 4'hA},
        {5'b10111, 2'b10, 4'hB},
        {5'b11010, 2'b10, 4'hC},
        {5'b11011, 2'b10, 4'hD},
        {5'b11100, 2'b10, 4'hE},
        {5'b11101, 2'b10, 4'hF},
        {C_T,      2'b00, 4'h0},
        {C_R,      2'b00, 4'h0},
        {C_I,      2'b00, 4'h0},
        {C_J,      2'b10, 4'h5},
        {C_I,      2'b01, 4'hE},
        {C_T,      2'b00, 4'h0},
        {5'b01001, 2'b00, 4'h0}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       cg_valid;
    logic [4:0] cg_data;
    logic       rx_dv;
    logic       rx_er;
    logic [3:0] rxd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rx5b_decoder uut (
        .clk      (clk),
        .rst      (rst),
        .cg_valid (cg_valid),
        .cg_data  (cg_data),
        .rx_dv    (rx_dv),
        .rx_er    (rx_er),
        .rxd      (rxd)
    );

    task automatic check(input string tag, input logic dv, input logic er, input logic [3:0] nib);
        n_chk++;
        if (rx_dv !== dv || rx_er !== er || rxd !== nib) begin
            n_fail++;
            $display("FAIL %s: got dv=%b er=%b rxd=%h, expected dv=%b er=%b rxd=%h",
                     tag, rx_dv, rx_er, rxd, dv, er, nib);
        end
    endtask

    // drive at a falling edge, return one falling edge later
    task automatic feed(input logic [4:0] c, input logic v);
        cg_valid = v;
        cg_data  = c;
        @(negedge clk);
    endtask

    task automatic step(input string tag, input logic [4:0] c,
                        input logic dv, input logic er, input logic [3:0] nib);
        feed(c, 1'b1);
        check(tag, dv, er, nib);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        cg_valid = 1'b0;
        cg_data  = C_I;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", 1'b0, 1'b0, 4'h0);
        rst = 1'b0;

        // vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            step($sformatf("R2/R3/R4/R5/R6/R7 vec %0d", i),
                 VEC[i][10:6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
        end

        // invalid symbols inside a frame
        step("R4 J", C_J, 1'b1, 1'b0, 4'h5);
        step("R4 K", C_K, 1'b1, 1'b0, 4'h5);
        step("R10 code 00000", 5'b00000, 1'b1, 1'b1, 4'h0);
        step("R10 J in frame", C_J, 1'b1, 1'b1, 4'h0);
        step("R10 halt symbol", C_H, 1'b1, 1'b1, 4'h0);
        step("R10 decode continues", 5'b01010, 1'b1, 1'b0, 4'h4);

        // single and double IDLE
        step("R9 first idle", C_I, 1'b1, 1'b1, 4'h0);
        step("R9 data after idle", 5'b10100, 1'b1, 1'b0, 4'h2);
        step("R9 first idle again", C_I, 1'b1, 1'b1, 4'h0);
        step("R9 second idle", C_I, 1'b0, 1'b0, 4'h0);
        step("R9 searching after end", C_K, 1'b0, 1'b0, 4'h0);

        // T without R
        step("R4 J", C_J, 1'b1, 1'b0, 4'h5);
        step("R4 K", C_K, 1'b1, 1'b0, 4'h5);
        step("R7 T", C_T, 1'b0, 1'b0, 4'h0);
        step("R8 T then data", 5'b01001, 1'b0, 1'b1, 4'h0);
        step("R8 searching after bad end", C_K, 1'b0, 1'b0, 4'h0);

        // stall in a frame
        step("R3 J", C_J, 1'b1, 1'b0, 4'h5);
        step("R4 K", C_K, 1'b1, 1'b0, 4'h5);
        step("R6 data A", 5'b10110, 1'b1, 1'b0, 4'hA);
        for (int s = 0; s < 3; s++) begin
            feed(C_T, 1'b0);
            check("R11 stall hold", 1'b1, 1'b0, 4'hA);
        end
        step("R11 stalled T ignored", 5'b10101, 1'b1, 1'b0, 4'h3);
        step("R7 T", C_T, 1'b0, 1'b0, 4'h0);
        step("R7 R", C_R, 1'b0, 1'b0, 4'h0);

        // false carrier then stall
        step("R3 J", C_J, 1'b1, 1'b0, 4'h5);
        step("R5 J then J", C_J, 1'b0, 1'b1, 4'hE);
        feed(C_J, 1'b0);
        check("R11 hold false carrier", 1'b0, 1'b1, 4'hE);
        step("R2 after false carrier", C_K, 1'b0, 1'b0, 4'h0);

        // reset in mid-frame
        step("R3 J", C_J, 1'b1, 1'b0, 4'h5);
        step("R4 K", C_K, 1'b1, 1'b0, 4'h5);
        step("R6 data 7", 5'b01111, 1'b1, 1'b0, 4'h7);
        rst = 1'b1;
        feed(5'b01111, 1'b1);
        check("R1 reset mid-frame", 1'b0, 1'b0, 4'h0);
        rst = 1'b0;
        step("R1 search after reset", 5'b01111, 1'b0, 1'b0, 4'h0);
        step("R1 K alone after reset", C_K, 1'b0, 1'b0, 4'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule